// File: doc/BRIEF.md
# Gated Frequency and Period Measurement Counter

This block is a 20-bit measurement counter for a tuner controller. It can measure the frequency of a fast input (after a divide-by-two) or of a slow input by counting that input's rising edges over a gate time. It can also measure the period of the slow input by counting strobes from a fixed reference over one or two periods of that input. A control word is applied with a one-cycle load strobe. A load with the enable bit low clears the counter. A load with the enable bit high starts a measurement after a settle delay.

A load with the enable bit high that comes while the counter holds a value does not clear it. The new measurement is added to what is already there, which allows integrating counts over several measurements. Both signal inputs are asynchronous. Each passes through a synchroniser and a rising-edge detector that run on the system clock. The reference arrives as a single-cycle strobe, `ref_tick`, that is synchronous to the system clock and stands for the reference clock. Time is measured in units of `UNIT_CYC` clock cycles, and one unit stands for one millisecond.

Top module: `meas_counter`

## Requirements
- R1: The source select bits pick the mode: `ctl_cts1`=1 selects frequency measurement on `hi_in`; `ctl_cts1`=0 with `ctl_cts0`=1 selects frequency measurement on `lo_in`; both 0 selects period measurement on `lo_in`. The input that is not selected has no effect on the result.
- R2: In fast-input mode, only every second rising edge of `hi_in` inside the gate is counted. An increment of the result therefore equals floor(edges/2).
- R3: In slow-input frequency mode, each rising edge of `lo_in` inside the gate adds one to the result.
- R4: The gate lasts 4, 8, 32 or 64 units for `ctl_gt` = 00, 01, 10 or 11. `done` is first high exactly settle+gate clock cycles after the clock edge that samples the load.
- R5: The settle delay is 4 units when `ctl_gt[1]`=0 and 8 units when it is 1. Input edges during the settle delay are not counted.
- R6: In period mode, after the settle delay the counter waits for a rising edge of `lo_in`. It then counts `ref_tick` strobes until the next rising edge (`ctl_gt[1]`=0) or until the second rising edge after it (`ctl_gt[1]`=1). Strobes before the first edge, or after the end, are not counted.
- R7: After reset, and one cycle after a load with `ctl_cte`=0, `result` is 0 and `done` is low. A measurement in progress is abandoned, and later input edges are ignored.
- R8: A load with `ctl_cte`=1 does not clear `result`. Successive measurements add to it.
- R9: `done` rises only at the end of a measurement. It stays high, with `result` unchanged, until the next load, which clears it.
- R10: `result` wraps modulo 2^`CNT_W` and never changes by more than one per cycle, except when cleared.
- R11: A rising edge on a signal input counts at most once, however long the input stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_load | input | 1 | One-cycle strobe that applies the control word |
| ctl_cte | input | 1 | 1 starts a measurement, 0 clears the counter |
| ctl_cts1 | input | 1 | Source select, high bit |
| ctl_cts0 | input | 1 | Source select, low bit |
| ctl_gt | input | 2 | Gate time, or number of periods (bit 1) |
| hi_in | input | 1 | Fast signal input, asynchronous |
| lo_in | input | 1 | Slow signal input, asynchronous |
| ref_tick | input | 1 | Reference strobe for period measurement |
| result | output | CNT_W (20) | Accumulated count |
| done | output | 1 | End-of-measurement flag |

## Verification
The assertions check on every cycle the rules that must hold whatever the stimulus is:
- the count is frozen while idle, settling or armed;
- the fast-input count is frozen on odd edges;
- in period mode, only a reference strobe can move the count;
- the count steps by at most one;
- a clearing load zeroes the result and the flag;
- the flag rises only out of a measurement;
- a held input yields a single edge.

Only the bench scenarios can show the values themselves:
- the halved fast-input counts, and the input selection;
- the exact gate and settle durations for each gate code;
- the reference counts over one or two periods;
- accumulation across repeated loads, and wrap-around in a narrow instance.

// File: rtl/meas_counter_pkg.sv
package meas_counter_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_GATE,
    ST_ARM,
    ST_PERIOD
  } mc_state_e;

  typedef enum logic [1:0] {
    SRC_HIGH_FREQ,
    SRC_LOW_FREQ,
    SRC_LOW_PERIOD
  } mc_src_e;

  localparam int unsigned MAX_GATE_UNITS = 64;

  function automatic mc_src_e decode_src(input logic cts1, input logic cts0);
    if (cts1) return SRC_HIGH_FREQ;
    if (cts0) return SRC_LOW_FREQ;
    return SRC_LOW_PERIOD;
  endfunction

  // Gate length in time units for each gate code.
  function automatic int unsigned gate_units(input logic [1:0] gt);
    int unsigned u;
    case (gt)
      2'b00:   u = 4;
      2'b01:   u = 8;
      2'b10:   u = 32;
      default: u = 64;
    endcase
    return u;
  endfunction

  // Settle delay in time units; the long gates use the long delay.
  function automatic int unsigned settle_units(input logic gt_hi);
    return gt_hi ? 8 : 4;
  endfunction

  // Number of slow-input periods spanned in period mode.
  function automatic int unsigned period_spans(input logic gt_hi);
    return gt_hi ? 2 : 1;
  endfunction

endpackage

// File: rtl/meas_edge_sync.sv
module meas_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], din};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R11

endmodule

// File: rtl/meas_interval_timer.sv
module meas_interval_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] load_val,
  output logic         expire
);
  logic [W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= '0;
    else if (start)          remain <= load_val;
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign expire = (remain == W'(1));

  AST_EXPIRE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !start) |=> !expire); // R4

endmodule

// File: rtl/meas_accum.sv
module meas_accum #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         inc,
  output logic [W-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     value <= '0;
    else if (clear) value <= '0;
    else if (inc)   value <= value + 1'b1;
  end

  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (value == $past(value) || value == $past(value) + W'(1) || value == '0)); // R10

endmodule

// File: rtl/meas_counter.sv
module meas_counter
  import meas_counter_pkg::*;
#(
  parameter int CNT_W       = 20,
  parameter int UNIT_CYC    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_load,
  input  logic             ctl_cte,
  input  logic             ctl_cts1,
  input  logic             ctl_cts0,
  input  logic [1:0]       ctl_gt,
  input  logic             hi_in,
  input  logic             lo_in,
  input  logic             ref_tick,
  output logic [CNT_W-1:0] result,
  output logic             done
);
  localparam int TMR_W  = $clog2(MAX_GATE_UNITS * UNIT_CYC + 1);
  localparam int NUM_IN = 2;
  localparam int IDX_HI = 0;
  localparam int IDX_LO = 1;

  // ---------------- input synchronisers ----------------
  logic [NUM_IN-1:0] raw_in, in_rise;
  assign raw_in = {lo_in, hi_in};

  generate
    for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_sync
      meas_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in[gi]),
        .rise (in_rise[gi])
      );
    end
  endgenerate

  logic hi_rise, lo_rise;
  assign hi_rise = in_rise[IDX_HI];
  assign lo_rise = in_rise[IDX_LO];

  // ---------------- control state ----------------
  mc_state_e  state_q, state_d;
  mc_src_e    src_q;
  logic [1:0] gt_q;
  logic [1:0] span_q;
  logic       hi_phase_q;
  logic       done_q;

  logic meas_start, meas_stop;
  assign meas_start = ctl_load &  ctl_cte;
  assign meas_stop  = ctl_load & ~ctl_cte;

  // ---------------- timer ----------------
  logic             tmr_start, tmr_expire;
  logic [TMR_W-1:0] tmr_load, settle_len, gate_len;

  assign settle_len = TMR_W'(settle_units(ctl_gt[1]) * UNIT_CYC);
  assign gate_len   = TMR_W'(gate_units(gt_q) * UNIT_CYC);

  // named internal events
  logic settle_done, gate_start, arm_start, gate_open, period_open;
  logic gate_end, period_end, meas_end, busy, last_span, count_inc;

  assign settle_done = (state_q == ST_SETTLE) & tmr_expire & ~ctl_load;
  assign gate_start  = settle_done & (src_q != SRC_LOW_PERIOD);
  assign arm_start   = settle_done & (src_q == SRC_LOW_PERIOD);
  assign gate_open   = (state_q == ST_GATE);
  assign period_open = (state_q == ST_PERIOD);
  assign busy        = (state_q != ST_IDLE);
  assign last_span   = (span_q == 2'(period_spans(gt_q[1]) - 1));
  assign gate_end    = gate_open & tmr_expire & ~ctl_load;
  assign period_end  = period_open & lo_rise & last_span & ~ctl_load;
  assign meas_end    = gate_end | period_end;

  assign tmr_start = meas_start | gate_start;
  assign tmr_load  = meas_start ? settle_len : gate_len;

  meas_interval_timer #(.W(TMR_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (tmr_start),
    .load_val(tmr_load),
    .expire  (tmr_expire)
  );

  // ---------------- next state ----------------
  always_comb begin
    state_d = state_q;
    if (meas_stop) begin
      state_d = ST_IDLE;
    end else if (meas_start) begin
      state_d = ST_SETTLE;
    end else begin
      case (state_q)
        ST_SETTLE: begin
          if (gate_start)     state_d = ST_GATE;
          else if (arm_start) state_d = ST_ARM;
        end
        ST_GATE:   if (gate_end)   state_d = ST_IDLE;
        ST_ARM:    if (lo_rise)    state_d = ST_PERIOD;
        ST_PERIOD: if (period_end) state_d = ST_IDLE;
        default:   state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      src_q      <= SRC_HIGH_FREQ;
      gt_q       <= 2'b00;
      span_q     <= 2'd0;
      hi_phase_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      state_q <= state_d;

      if (ctl_load) begin
        src_q <= decode_src(ctl_cts1, ctl_cts0);
        gt_q  <= ctl_gt;
      end

      if (meas_start || (state_q == ST_ARM && lo_rise))
        span_q <= 2'd0;
      else if (period_open && lo_rise)
        span_q <= span_q + 2'd1;

      if (gate_start)
        hi_phase_q <= 1'b0;
      else if (gate_open && hi_rise)
        hi_phase_q <= ~hi_phase_q;

      if (ctl_load)      done_q <= 1'b0;
      else if (meas_end) done_q <= 1'b1;
    end
  end

  // ---------------- counting ----------------
  assign count_inc = ~ctl_load & (
      (gate_open & (src_q == SRC_HIGH_FREQ) & hi_rise & hi_phase_q) |
      (gate_open & (src_q == SRC_LOW_FREQ)  & lo_rise) |
      (period_open & ref_tick));

  meas_accum #(.W(CNT_W)) u_accum (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(meas_stop),
    .inc  (count_inc),
    .value(result)
  );

  assign done = done_q;

  // ---------------- assertions ----------------
  AST_CLEAR_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_load && !ctl_cte) |=> (result == '0 && !done)); // R7

  AST_DONE_DROPS_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_load && ctl_cte) |=> !done); // R9

  AST_DONE_FROM_MEAS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy)); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ctl_load) |=> $stable(result)); // R8

  AST_SETTLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETTLE && !ctl_load) |=> $stable(result)); // R5

  AST_ARM_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARM && !ctl_load) |=> $stable(result)); // R6

  AST_PERIOD_REF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (period_open && !ref_tick && !ctl_load) |=> $stable(result)); // R6

  AST_HALF_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_open && src_q == SRC_HIGH_FREQ && !hi_phase_q && !ctl_load) |=> $stable(result)); // R2

endmodule

// File: tb/meas_counter_tb_top.sv
module meas_counter_tb_top;
  localparam int UNIT = 16;
  localparam int W    = 20;
  localparam int SW   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic ctl_load = 0, ctl_cte = 0, ctl_cts1 = 0, ctl_cts0 = 0;
  logic [1:0] ctl_gt = 2'b00;
  logic hi_in = 0, lo_in = 0, ref_tick = 0;
  logic [W-1:0]  result;
  logic          done;
  logic [SW-1:0] result_s;
  logic          done_s;

  meas_counter #(.CNT_W(W), .UNIT_CYC(UNIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_load(ctl_load), .ctl_cte(ctl_cte),
    .ctl_cts1(ctl_cts1), .ctl_cts0(ctl_cts0), .ctl_gt(ctl_gt),
    .hi_in(hi_in), .lo_in(lo_in), .ref_tick(ref_tick),
    .result(result), .done(done));

  meas_counter #(.CNT_W(SW), .UNIT_CYC(UNIT)) wrap_i (
    .clk(clk), .rst_n(rst_n), .ctl_load(ctl_load), .ctl_cte(ctl_cte),
    .ctl_cts1(ctl_cts1), .ctl_cts0(ctl_cts0), .ctl_gt(ctl_gt),
    .hi_in(hi_in), .lo_in(lo_in), .ref_tick(ref_tick),
    .result(result_s), .done(done_s));

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;
  int t0 = 0;
  longint acc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check_eq(string req, longint act, longint expv);
    n_checks++;
    if (act != expv) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // ---------------- scoreboard ----------------
  typedef struct {
    string  tag;
    longint val;
  } exp_t;
  exp_t exp_q[$];
  exp_t mon_item;
  logic done_prev = 0;

  task automatic push_exp(string tag, longint v);
    exp_t e;
    e.tag = tag;
    e.val = v;
    exp_q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rst_n && done && !done_prev) begin
      if (exp_q.size() == 0) begin
        n_checks++;
        n_errors++;
        $display("FAIL R9: unexpected end of count, actual %0d expected none", result);
      end else begin
        mon_item = exp_q.pop_front();
        check_eq(mon_item.tag, result, mon_item.val);
        check_eq("R10 narrow wrap", result_s, mon_item.val % (1 << SW));
        check_eq("R9 narrow flag", done_s, 1);
      end
    end
    done_prev = done;
  end

  // ---------------- timing model ----------------
  function automatic int gate_cyc(logic [1:0] gt);
    return ((gt[1] ? 32 : 4) << gt[0]) * UNIT;
  endfunction

  function automatic int settle_cyc(logic gt_hi);
    return (4 << gt_hi) * UNIT;
  endfunction

  // ---------------- driver ----------------
  task automatic do_load(bit cte, bit c1, bit c0, logic [1:0] gt);
    @(negedge clk);
    ctl_cte = cte; ctl_cts1 = c1; ctl_cts0 = c0; ctl_gt = gt;
    ctl_load = 1;
    @(negedge clk);
    ctl_load = 0;
    t0 = cyc;
  endtask

  task automatic pulse_hi(int n);
    repeat (n) begin
      hi_in = 1; @(negedge clk); @(negedge clk);
      hi_in = 0; @(negedge clk); @(negedge clk);
    end
  endtask

  task automatic pulse_lo(int n);
    repeat (n) begin
      lo_in = 1; @(negedge clk); @(negedge clk);
      lo_in = 0; @(negedge clk); @(negedge clk);
    end
  endtask

  task automatic pulse_ref(int n);
    repeat (n) begin
      ref_tick = 1; @(negedge clk);
      ref_tick = 0; @(negedge clk); @(negedge clk);
    end
  endtask

  task automatic wait_until(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic wait_done(output int m);
    while (!done) @(negedge clk);
    m = cyc - t0;
  endtask

  task automatic clear_ctr();
    do_load(0, 0, 0, 2'b00);
    acc = 0;
    check_eq("R7 clear result", result, 0);
    check_eq("R7 clear flag", done, 0);
  endtask

  task automatic freq_run(string tag, bit c1, bit c0, logic [1:0] gt,
                          int junk, int nhi, int nlo, bit long_lo);
    int s = settle_cyc(gt[1]);
    int g = gate_cyc(gt);
    int m;
    acc += c1 ? (nhi / 2) : (nlo + (long_lo ? 1 : 0));
    push_exp(tag, acc);
    do_load(1, c1, c0, gt);
    check_eq("R9 flag low after start", done, 0);
    fork
      pulse_hi(junk);
      pulse_lo(junk);
    join
    wait_until(t0 + s + 8);
    fork
      pulse_hi(nhi);
      pulse_lo(nlo);
    join
    if (long_lo) begin
      lo_in = 1;
      repeat (20) @(negedge clk);
      lo_in = 0;
      repeat (2) @(negedge clk);
    end
    wait_done(m);
    check_eq("R4 gate timing", m, s + g);
  endtask

  task automatic period_run(string tag, bit gt_hi, int k1, int k2);
    int s = settle_cyc(gt_hi);
    int m;
    acc += gt_hi ? (k1 + k2) : k1;
    push_exp(tag, acc);
    do_load(1, 0, 0, {gt_hi, 1'b0});
    wait_until(t0 + s + 8);
    pulse_ref(3);
    lo_in = 1; repeat (6) @(negedge clk);
    lo_in = 0; repeat (6) @(negedge clk);
    pulse_ref(k1);
    repeat (6) @(negedge clk);
    lo_in = 1; repeat (6) @(negedge clk);
    lo_in = 0; repeat (6) @(negedge clk);
    if (gt_hi) begin
      pulse_ref(k2);
      repeat (6) @(negedge clk);
      lo_in = 1; repeat (6) @(negedge clk);
      lo_in = 0; repeat (6) @(negedge clk);
    end
    wait_done(m);
    pulse_ref(4);
    check_eq("R6 refs after end ignored", result, acc);
  endtask

  // ---------------- scenarios ----------------
  initial begin
    longint held;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_eq("R7 reset result", result, 0);
    check_eq("R7 reset flag", done, 0);

    clear_ctr();
    freq_run("R3/R5 slow freq gt00", 0, 1, 2'b00, 3, 6, 7, 0);
    clear_ctr();
    freq_run("R2/R1 fast freq gt01", 1, 0, 2'b01, 3, 9, 5, 0);
    clear_ctr();
    freq_run("R2/R1 fast freq gt10", 1, 1, 2'b10, 2, 30, 3, 0);
    clear_ctr();
    freq_run("R3/R11 slow freq gt11", 0, 1, 2'b11, 4, 2, 40, 1);
    clear_ctr();
    period_run("R6 one period", 0, 5, 0);
    clear_ctr();
    period_run("R6 two periods", 1, 4, 6);

    clear_ctr();
    freq_run("R8 first pass", 0, 1, 2'b00, 0, 0, 10, 0);
    freq_run("R8/R10 accumulate", 0, 1, 2'b00, 0, 4, 10, 0);

    held = result;
    repeat (50) @(negedge clk);
    pulse_lo(3);
    pulse_ref(3);
    check_eq("R9 flag held", done, 1);
    check_eq("R9 result held", result, held);
    do_load(1, 0, 1, 2'b00);
    check_eq("R9 flag cleared by load", done, 0);
    check_eq("R8 no clear on start", result, held);

    // abandon a measurement in progress
    clear_ctr();
    do_load(1, 0, 1, 2'b11);
    wait_until(t0 + settle_cyc(1'b1) + 20);
    pulse_lo(5);
    clear_ctr();
    pulse_lo(5);
    repeat (1500) @(negedge clk);
    check_eq("R7 abort result", result, 0);
    check_eq("R7 abort flag", done, 0);

    check_eq("R9 all results seen", exp_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule